// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

This core moves 8-bit channels between serial time-division multiplexed streams. Every input stream carries one bit per bit clock, grouped into 125 µs frames. A frame pulse sampled high marks the last bit cycle of a frame. Each input stream is shifted into bytes, MSB first. The bytes are written into a data store split into two halves, and the half alternates on every frame boundary. While the new frame is captured into one half, the outputs are built from the other half, which holds the last complete frame.

Each output channel of each output stream has one connection word, written by a processor. A connection word either names a source stream and source channel to copy from, or, in message mode, carries a constant byte that is sent in that channel every frame. The frame length follows a rate select input: 32, 64 or 128 channels per frame for 2.048, 4.096 or 8.192 Mbit/s. A new rate is only taken over at a frame boundary. If the frame pulse goes missing, the frame counter keeps running on its own.

Top module: `tsi_core`

## Requirements
- R1: After reset, and until the first frame pulse is sampled, every serial output is held at 0.
- R2: The bit cycle right after the cycle in which the frame pulse is sampled is bit cycle 0. Bit b of channel c is carried in bit cycle 8*c+7-b, on inputs and outputs alike (MSB first).
- R3: The connection word is 10 bits wide: bit 9 = 0 selects switching, bits 8:7 give the source stream, and bits 6:0 give the source channel. With bit 9 = 0, the output channel sends the byte received on that source in the previous frame.
- R4: When bit 9 of the connection word is 1, bits 7:0 of the word are sent in that output channel every frame.
- R5: rate_sel 0, 1 and 2 give frames of 32, 64 and 128 channels (256, 512, 1024 bit cycles). The value 3 acts as 2.
- R6: A change of rate_sel in the middle of a frame leaves the current frame at its old length. The new length applies from the next frame boundary.
- R7: An output channel always gets data from the previous complete frame. This holds when its source is a later channel of the same frame, and also when its source is the last channel of the frame and the output channel is channel 0 (the source byte completes on the same edge that loads the output).
- R8: A connection write takes effect for a channel whose output load edge comes after the write edge. The load edge for channel c is the clock edge that ends bit cycle 8*c-1.
- R9: When no frame pulse arrives, the counter wraps by itself after the frame length and flips the data-store half. Switching goes on without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during the last bit cycle of a frame |
| rate_sel | input | 2 | Rate select: 0 = 32, 1 = 64, 2 or 3 = 128 channels |
| ser_in | input | 4 | Serial input streams |
| ser_out | output | 4 | Serial output streams |
| cm_we | input | 1 | Connection word write strobe |
| cm_stream | input | 2 | Output stream of the connection word |
| cm_chan | input | 7 | Output channel of the connection word |
| cm_data | input | 10 | Connection word (mode, source stream, source channel or message byte) |

## Verification
An output bit for bit cycle n is registered on the edge that opens cycle n. The bench reads it at the falling edge inside that cycle and drives input bit n at the same point, so the design samples the input at the edge that closes cycle n. Each switched byte is compared with the input byte of the same source one frame earlier. Message bytes are compared within the frame in which they are programmed. Connection writes during a running frame are issued in bit cycle 0 and aimed only at channels 8 or higher, so their load edge is at least seven cycles later and the new value is due in that same frame.

// File: rtl/tsi_pkg.sv
// Shared definitions for the time-slot interchange core.
// Assumes rate codes grow by a factor of two in channels per frame.
package tsi_pkg;

    typedef enum logic [1:0] {
        RATE_32CH  = 2'd0,
        RATE_64CH  = 2'd1,
        RATE_128CH = 2'd2,
        RATE_SPARE = 2'd3
    } rate_code_e;

    // Clamp a requested rate code to the highest supported one.
    function automatic logic [1:0] clamp_rate(input logic [1:0] req, input int unsigned n_rates);
        logic [1:0] top;
        top = 2'(n_rates - 1);
        return (req > top) ? top : req;
    endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
// Frame timer: counts bit cycles within a frame, flips the data-store half
// on every frame boundary and takes over the rate code only there.
// Assumes the frame pulse is high during the last bit cycle of a frame.
module tsi_frame_timer #(
    parameter int BASE_CH   = 32,
    parameter int NUM_RATES = 3,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] next_cnt,
    output logic             half,
    output logic             next_half,
    output logic             running,
    output logic             frame_start
);
    import tsi_pkg::*;

    localparam logic [CNT_W:0] BASE_BITS = (CNT_W+1)'(BASE_CH * 8);

    logic [1:0]     rate_act;
    logic [CNT_W:0] frame_bits;
    logic           at_last;

    // Frame length in bit cycles for the active rate.
    always_comb begin
        frame_bits = BASE_BITS << rate_act;
        at_last    = running && ({1'b0, bit_cnt} == (frame_bits - (CNT_W+1)'(1)));
    end

    // Next-state values shared with the lanes for one-cycle look-ahead.
    always_comb begin
        frame_start = fp_i || at_last;
        if (frame_start)
            next_cnt = '0;
        else if (running)
            next_cnt = bit_cnt + CNT_W'(1);
        else
            next_cnt = '0;
        next_half = frame_start ? ~half : half;
    end

    // Counter, half and rate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            half     <= 1'b0;
            running  <= 1'b0;
            rate_act <= RATE_32CH;
        end else begin
            bit_cnt <= next_cnt;
            half    <= next_half;
            if (fp_i)
                running <= 1'b1;
            if (frame_start)
                rate_act <= clamp_rate(rate_sel, NUM_RATES);
        end
    end

    // R2: a sampled frame pulse restarts the count at bit cycle 0.
    p_pulse_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> (bit_cnt == '0));

    // R5: while running, the count stays inside the active frame.
    p_cnt_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ({1'b0, bit_cnt} < frame_bits));

    // R6: the active rate only changes at a frame boundary.
    p_rate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !frame_start) |=> $stable(rate_act));

    // R9: without a pulse the frame wraps by itself and flips the half.
    p_flywheel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && !fp_i) |=> ((bit_cnt == '0) && (half != $past(half))));

endmodule

// File: rtl/tsi_rx_lane.sv
// Receive lane: shifts one serial input, MSB first, and offers a completed
// byte with its channel number on the last bit cycle of each channel.
// Assumes the frame timer count marks bit position within the channel.
module tsi_rx_lane #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             ser_i,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic             wr_en,
    output logic [CNT_W-4:0] wr_chan,
    output logic [7:0]       wr_byte
);
    logic [6:0] shreg;

    // Collect the first seven bits of the current channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (running)
            shreg <= {shreg[5:0], ser_i};
    end

    // Offer the full byte while its last bit is on the line.
    always_comb begin
        wr_en   = running && (bit_cnt[2:0] == 3'd7);
        wr_chan = bit_cnt[CNT_W-1:3];
        wr_byte = {shreg, ser_i};
    end

endmodule

// File: rtl/tsi_data_store.sv
// Two-half data store: each receive lane writes its own stream region of
// the half being filled; each transmit lane reads any stream and channel.
// A read that hits a byte being written on the same edge returns the new
// byte, so channel 0 can take the last channel of the frame just ended.
module tsi_data_store #(
    parameter int NS    = 4,
    parameter int NCH   = 128,
    parameter int SEL_W = 2,
    parameter int CH_W  = 7
) (
    input  logic                       clk,
    input  logic                       wr_half,
    input  logic [NS-1:0]              wr_en,
    input  logic [NS-1:0][CH_W-1:0]    wr_chan,
    input  logic [NS-1:0][7:0]         wr_byte,
    input  logic                       rd_half,
    input  logic [NS-1:0][SEL_W-1:0]   rd_stream,
    input  logic [NS-1:0][CH_W-1:0]    rd_chan,
    output logic [NS-1:0][7:0]         rd_byte
);
    localparam int DEPTH = 2 * (2 ** SEL_W) * NCH;

    logic [7:0] mem [DEPTH];

    // Store completed bytes of every stream into the half being filled.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NS; w++) begin
            if (wr_en[w])
                mem[{wr_half, SEL_W'(w), wr_chan[w]}] <= wr_byte[w];
        end
    end

    // Read ports with forwarding of a same-edge write to the same byte.
    always_comb begin
        for (int r = 0; r < NS; r++) begin
            rd_byte[r] = mem[{rd_half, rd_stream[r], rd_chan[r]}];
            for (int w = 0; w < NS; w++) begin
                if (wr_en[w] && (wr_half == rd_half) &&
                    (SEL_W'(w) == rd_stream[r]) && (wr_chan[w] == rd_chan[r]))
                    rd_byte[r] = wr_byte[w];
            end
        end
    end

endmodule

// File: rtl/tsi_conn_store.sv
// Connection store: one word per output stream and channel, written by a
// processor port and read for all output streams at the same channel.
// Assumes a write and a read of one word on the same edge returns the old word.
module tsi_conn_store #(
    parameter int NS    = 4,
    parameter int NCH   = 128,
    parameter int SEL_W = 2,
    parameter int CH_W  = 7,
    parameter int CM_W  = 10
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [SEL_W-1:0]         wr_stream,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic [CM_W-1:0]          wr_word,
    input  logic [CH_W-1:0]          rd_chan,
    output logic [NS-1:0][CM_W-1:0]  rd_word
);
    localparam int DEPTH = (2 ** SEL_W) * NCH;

    logic [CM_W-1:0] mem [DEPTH];

    // Processor write of one connection word.
    always_ff @(posedge clk) begin
        if (we)
            mem[{wr_stream, wr_chan}] <= wr_word;
    end

    // Read the word of the upcoming channel for every output stream.
    always_comb begin
        for (int r = 0; r < NS; r++)
            rd_word[r] = mem[{SEL_W'(r), rd_chan}];
    end

endmodule

// File: rtl/tsi_tx_lane.sv
// Transmit lane: loads a byte at the start of each channel and shifts it
// out MSB first from a register, so the output bit changes only at an edge.
// Assumes the load strobe is aligned to the edge that opens bit cycle 0 of a channel.
module tsi_tx_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_i,
    output logic       ser_o
);
    logic [7:0] shreg;

    // Load a new channel byte or move on to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= byte_i;
        else
            shreg <= {shreg[6:0], 1'b0};
    end

    assign ser_o = shreg[7];

    // R2: the first bit sent in a channel is the MSB of the loaded byte.
    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_o == $past(byte_i[7])));

endmodule

// File: rtl/tsi_core.sv
// Time-slot interchange core: receive lanes fill a two-half data store,
// and per output channel a connection word picks a switched byte from the
// previous frame or a constant message byte for each transmit lane.
// Assumes one bit clock for all streams and a rate shared by inputs and outputs.
module tsi_core #(
    parameter int NUM_STREAMS = 4,
    parameter int BASE_CH     = 32,
    parameter int NUM_RATES   = 3,
    localparam int MAX_CH     = BASE_CH << (NUM_RATES - 1),
    localparam int CH_W       = $clog2(MAX_CH),
    localparam int SEL_W      = $clog2(NUM_STREAMS),
    localparam int CNT_W      = CH_W + 3,
    localparam int CM_W       = 1 + (((SEL_W + CH_W) > 8) ? (SEL_W + CH_W) : 8)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fp_i,
    input  logic [1:0]             rate_sel,
    input  logic [NUM_STREAMS-1:0] ser_in,
    output logic [NUM_STREAMS-1:0] ser_out,
    input  logic                   cm_we,
    input  logic [SEL_W-1:0]       cm_stream,
    input  logic [CH_W-1:0]        cm_chan,
    input  logic [CM_W-1:0]        cm_data
);
    localparam int MODE_BIT = CM_W - 1;

    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             half;
    logic             next_half;
    logic             running;
    logic             frame_start;
    logic             load;

    logic [NUM_STREAMS-1:0]             wr_en;
    logic [NUM_STREAMS-1:0][CH_W-1:0]   wr_chan;
    logic [NUM_STREAMS-1:0][7:0]        wr_byte;
    logic [NUM_STREAMS-1:0][SEL_W-1:0]  rd_stream;
    logic [NUM_STREAMS-1:0][CH_W-1:0]   rd_chan;
    logic [NUM_STREAMS-1:0][7:0]        rd_byte;
    logic [NUM_STREAMS-1:0][CM_W-1:0]   cm_word;
    logic [NUM_STREAMS-1:0][7:0]        tx_byte;

    tsi_frame_timer #(
        .BASE_CH   (BASE_CH),
        .NUM_RATES (NUM_RATES),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_i),
        .rate_sel    (rate_sel),
        .bit_cnt     (bit_cnt),
        .next_cnt    (next_cnt),
        .half        (half),
        .next_half   (next_half),
        .running     (running),
        .frame_start (frame_start)
    );

    // A channel byte is loaded on the edge that opens its bit cycle 0.
    assign load = (running || fp_i) && (next_cnt[2:0] == 3'd0);

    tsi_data_store #(
        .NS    (NUM_STREAMS),
        .NCH   (MAX_CH),
        .SEL_W (SEL_W),
        .CH_W  (CH_W)
    ) u_dstore (
        .clk       (clk),
        .wr_half   (half),
        .wr_en     (wr_en),
        .wr_chan   (wr_chan),
        .wr_byte   (wr_byte),
        .rd_half   (~next_half),
        .rd_stream (rd_stream),
        .rd_chan   (rd_chan),
        .rd_byte   (rd_byte)
    );

    tsi_conn_store #(
        .NS    (NUM_STREAMS),
        .NCH   (MAX_CH),
        .SEL_W (SEL_W),
        .CH_W  (CH_W),
        .CM_W  (CM_W)
    ) u_cstore (
        .clk       (clk),
        .we        (cm_we),
        .wr_stream (cm_stream),
        .wr_chan   (cm_chan),
        .wr_word   (cm_data),
        .rd_chan   (next_cnt[CNT_W-1:3]),
        .rd_word   (cm_word)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
        tsi_rx_lane #(
            .CNT_W (CNT_W)
        ) u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .running (running),
            .ser_i   (ser_in[s]),
            .bit_cnt (bit_cnt),
            .wr_en   (wr_en[s]),
            .wr_chan (wr_chan[s]),
            .wr_byte (wr_byte[s])
        );

        // Decode the connection word into a source address or a message byte.
        always_comb begin
            rd_stream[s] = cm_word[s][CH_W+SEL_W-1:CH_W];
            rd_chan[s]   = cm_word[s][CH_W-1:0];
            tx_byte[s]   = cm_word[s][MODE_BIT] ? cm_word[s][7:0] : rd_byte[s];
        end

        tsi_tx_lane u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .byte_i (tx_byte[s]),
            .ser_o  (ser_out[s])
        );

        // R4: a message-mode word puts its byte MSB on the line next cycle.
        p_message_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (load && cm_word[s][MODE_BIT]) |=> (ser_out[s] == $past(cm_word[s][7])));
    end

    // R1: outputs stay low until the first frame pulse has been taken.
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (ser_out == '0));

endmodule

// File: tb/tb_tsi_core.sv
// Bench for tsi_core: random channel data and random connection words per
// rate, plus directed words for alignment, wrap, forwarding and rate change.
module tb_tsi_core;
    localparam int CLK_P = 10;
    localparam int NS    = 4;
    localparam int MAXC  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp_i = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [3:0] ser_in = '0;
    logic [3:0] ser_out;
    logic       cm_we = 1'b0;
    logic [1:0] cm_stream = '0;
    logic [6:0] cm_chan = '0;
    logic [9:0] cm_data = '0;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] cur_in  [NS][MAXC];
    logic [7:0] prev_in [NS][MAXC];
    logic [7:0] got     [NS][MAXC];
    logic [9:0] cmm     [NS][MAXC];
    int mut_o, mut_c;

    tsi_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_i      (fp_i),
        .rate_sel  (rate_sel),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .cm_we     (cm_we),
        .cm_stream (cm_stream),
        .cm_chan   (cm_chan),
        .cm_data   (cm_data)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        #(CLK_P * 200000);
        n_errors++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] sw_word(input int s, input int c);
        return {1'b0, 2'(s), 7'(c)};
    endfunction

    function automatic logic [9:0] msg_word(input logic [7:0] b);
        return {2'b10, b};
    endfunction

    // Program every connection word for a frame of nch channels while held in reset.
    task automatic program_cm(input int nch);
        for (int o = 0; o < NS; o++) begin
            for (int c = 0; c < MAXC; c++) begin
                if (($urandom % 4) == 0)
                    cmm[o][c] = msg_word(8'($urandom));
                else
                    cmm[o][c] = sw_word($urandom % NS, $urandom % nch);
            end
        end
        cmm[3][0]     = msg_word(8'hA5);
        cmm[3][nch-1] = msg_word(8'h3C);
        cmm[0][0]     = sw_word(3, nch - 1);
        cmm[2][5]     = sw_word(2, 6);
        cmm[1][nch-1] = sw_word(0, 0);
        for (int o = 0; o < NS; o++) begin
            for (int c = 0; c < MAXC; c++) begin
                @(negedge clk);
                cm_we = 1'b1; cm_stream = 2'(o); cm_chan = 7'(c); cm_data = cmm[o][c];
            end
        end
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    // One frame of nch channels: drive inputs, capture outputs, then compare.
    task automatic run_frame(input int nch, input bit with_fp, input bit cmp,
                             input bit mutate, input int chg, input string ftag);
        int nbits = nch * 8;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < nch; c++)
                cur_in[s][c] = 8'($urandom);
        mut_o = -1; mut_c = -1;
        for (int n = 0; n < nbits; n++) begin
            @(negedge clk);
            for (int o = 0; o < NS; o++)
                got[o][n/8][7-(n%8)] = ser_out[o];
            for (int s = 0; s < NS; s++)
                ser_in[s] = cur_in[s][n/8][7-(n%8)];
            fp_i = with_fp && (n == nbits - 1);
            cm_we = 1'b0;
            if (mutate && n == 0) begin
                // R8: write issued in bit cycle 0 to a channel loaded 7+ cycles later.
                mut_o = $urandom % NS;
                mut_c = 8 + ($urandom % (nch - 10));
                cmm[mut_o][mut_c] = msg_word(8'($urandom));
                cm_we = 1'b1; cm_stream = 2'(mut_o); cm_chan = 7'(mut_c);
                cm_data = cmm[mut_o][mut_c];
            end
            if (chg >= 0 && n == nbits / 2)
                rate_sel = 2'(chg);
        end
        if (cmp) begin
            for (int o = 0; o < NS; o++) begin
                for (int c = 0; c < nch; c++) begin
                    logic [9:0] w = cmm[o][c];
                    string tag;
                    logic [7:0] exp;
                    if (w[9]) begin
                        exp = w[7:0];
                        tag = "R4";
                    end else begin
                        if (int'(w[6:0]) >= nch) continue;
                        exp = prev_in[w[8:7]][w[6:0]];
                        tag = "R3";
                    end
                    if (ftag != "") tag = ftag;
                    else if (o == mut_o && c == mut_c) tag = "R8";
                    else if (o == 3 && c == 0) tag = "R2";
                    else if (o == 3 && c == nch - 1) tag = "R5";
                    else if ((o == 0 && c == 0) || (o == 2 && c == 5)) tag = "R7";
                    check($sformatf("%s out%0d ch%0d", tag, o, c), got[o][c], exp);
                end
            end
        end
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < MAXC; c++)
                prev_in[s][c] = cur_in[s][c];
    endtask

    // Reset, program, check idle outputs, then run frames at one rate.
    task automatic run_phase(input int rate, input int nfr, input int nofp_idx, input int chg);
        int nch = 32 << ((rate > 2) ? 2 : rate);
        @(negedge clk);
        rst_n = 1'b0; fp_i = 1'b0; ser_in = '0; rate_sel = 2'(rate);
        program_cm(nch);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ser_in = 4'($urandom);
            check("R1 idle output", {4'b0, ser_out}, 8'h00);
        end
        @(negedge clk);
        fp_i = 1'b1;
        run_frame(nch, 1'b1, 1'b0, 1'b0, -1, "");
        for (int f = 1; f < nfr; f++) begin
            bit last = (f == nfr - 1);
            run_frame(nch, (f != nofp_idx), 1'b1, (f % 2 == 0),
                      (last ? chg : -1),
                      (f == nofp_idx) ? "R9" : ((last && chg >= 0) ? "R6" : ""));
        end
        if (chg >= 0)
            run_frame(32 << chg, 1'b1, 1'b1, 1'b0, -1, "R6");
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        run_phase(2, 5, 2, -1);
        run_phase(0, 6, 3, -1);
        run_phase(3, 3, -1, -1);
        run_phase(1, 5, 2, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule